// File: doc/BRIEF.md
# Presettable Two-Decade Down Counter

This block is an eight-bit synchronous down counter. It can be loaded from a parallel jam bus and chained to other stages to make longer counts. A build-time parameter chooses how the eight bits are read. In decimal mode they hold two BCD digits: the units digit sits in bits 3:0 and the tens digit in bits 7:4, and the count runs from 99 down to 00. In binary mode they hold one unsigned value, and the count runs from 255 down to 0. Clearing the counter sets it to its top value, not to zero. When the count reaches zero and counting stays enabled, the next clock brings it back to the top. A full cycle therefore takes 100 clocks in decimal mode and 256 clocks in binary mode.

The control inputs are all active low and have a fixed order of priority. Clear comes first and acts at once, with no clock needed. The asynchronous load comes second and also acts at once. The synchronous load comes third and takes effect on the next rising edge. The count enable comes last. The carry-out goes low when the count is zero while counting is enabled. To build a longer counter, connect one stage's carry-out to the next stage's enable. The next stage then steps down once for each time the earlier stage wraps.

Top module: `ddc_top`

## Requirements
- R1: While rst_ni is low, count_o equals the maximum value: 8'h99 in decimal mode and 8'hFF in binary mode. This takes effect without a clock edge.
- R2: While aload_ni is low and rst_ni is high, count_o takes jam_i at once. It keeps the jam value across clock edges, whatever sload_ni and cnt_en_ni are doing.
- R3: When rst_ni and aload_ni are both low, rst_ni wins and count_o holds the maximum value.
- R4: If sload_ni is low and neither asynchronous input is active, count_o takes jam_i at the next rising edge. This holds even when cnt_en_ni is low.
- R5: If cnt_en_ni is high and no load or clear is active, count_o keeps its value across clock edges.
- R6: If cnt_en_ni is low and no load or clear is active, each rising edge lowers the count by one. In decimal mode a units digit of 0 becomes 9 and lowers the tens digit by one.
- R7: From a count of zero with counting enabled, the next edge gives the maximum value. A full cycle takes 100 edges in decimal mode and 256 edges in binary mode.
- R8: co_no is low only when count_o is zero and cnt_en_ni is low.
- R9: In decimal mode a digit holding a code from 10 to 15 steps down by one on each borrow until it reaches 9. For example, 8'h1F reaches 8'h19 after six enabled edges.
- R10: In binary mode jam_i is read as one unsigned value. From 8'hA0, one enabled edge gives 8'h9F; in decimal mode the same step gives 8'h99.
- R11: Two binary stages can be chained by driving the upper stage's cnt_en_ni from the lower stage's co_no. Together they count down through a 16-bit range, and from 16'h0000 they wrap to 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous clear to maximum value, active low |
| aload_ni | input | 1 | Asynchronous load from jam_i, active low |
| sload_ni | input | 1 | Synchronous load from jam_i, active low |
| cnt_en_ni | input | 1 | Count enable and cascade carry-in, active low |
| jam_i | input | 8 | Parallel load value |
| count_o | output | 8 | Present count |
| co_no | output | 1 | Zero detect and cascade carry-out, active low |

## Verification
The count register is visible directly on count_o, so a wrong next-state value shows up on the port at the first edge after it is formed. A decimal borrow error shows as a digit that should read 9 but does not. A faulty wrap, or a wrong carry-out, shows up only near zero. An error in the carry-out logic either blocks the next stage or lets it step more than once per wrap. This becomes visible one clock later, on the upper byte of a cascaded pair, or as the wrong number of low carry-out pulses across a long run. Priority mistakes show up at once, without any clock edge, while both asynchronous inputs are held low.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int unsigned DIGIT_W = 4;

  function automatic logic [63:0] max_count(input bit bcd, input int unsigned n_dig);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < n_dig; i++) begin
      if (bcd) v[i*DIGIT_W +: DIGIT_W] = 4'd9;
      else     v[i*DIGIT_W +: DIGIT_W] = 4'hF;
    end
    return v;
  endfunction
endpackage

// File: rtl/ddc_next.sv
module ddc_next #(
  parameter int unsigned N_DIG    = 2,
  parameter bit          BCD_MODE = 1'b1,
  localparam int unsigned W       = N_DIG * ddc_pkg::DIGIT_W
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);
  localparam int unsigned DW = ddc_pkg::DIGIT_W;

  if (BCD_MODE) begin : g_bcd
    logic [N_DIG:0] borrow;
    assign borrow[0] = 1'b1;
    for (genvar d = 0; d < N_DIG; d++) begin : g_dig
      logic [DW-1:0] dig;
      assign dig          = cur_i[d*DW +: DW];
      assign borrow[d+1]  = borrow[d] && (dig == '0);
      // codes 10..15 step down toward 9 like any other non-zero digit
      assign nxt_o[d*DW +: DW] = !borrow[d]    ? dig :
                                 (dig == '0)   ? DW'(9) : dig - DW'(1);
    end
  end else begin : g_bin
    assign nxt_o = cur_i - W'(1);
  end
endmodule

// File: rtl/ddc_zero.sv
module ddc_zero #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cur_i,
  input  logic         cnt_en_ni,
  output logic         co_no
);
  assign co_no = ~((cur_i == '0) & ~cnt_en_ni);
endmodule

// File: rtl/ddc_top.sv
module ddc_top #(
  parameter int unsigned N_DIG    = 2,
  parameter bit          BCD_MODE = 1'b1,
  localparam int unsigned W       = N_DIG * ddc_pkg::DIGIT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         aload_ni,
  input  logic         sload_ni,
  input  logic         cnt_en_ni,
  input  logic [W-1:0] jam_i,
  output logic [W-1:0] count_o,
  output logic         co_no
);
  localparam logic [63:0] MAX64 = ddc_pkg::max_count(BCD_MODE, N_DIG);
  localparam logic [W-1:0] MAX_V = MAX64[W-1:0];

  logic [W-1:0] cnt_q, cnt_dec;

  ddc_next #(.N_DIG(N_DIG), .BCD_MODE(BCD_MODE)) u_next (
    .cur_i (cnt_q),
    .nxt_o (cnt_dec)
  );

  // zero and enabled -> decrement path already yields MAX_V via digit wrap
  always_ff @(posedge clk_i or negedge rst_ni or negedge aload_ni) begin
    if (!rst_ni)         cnt_q <= MAX_V;
    else if (!aload_ni)  cnt_q <= jam_i;
    else if (!sload_ni)  cnt_q <= jam_i;
    else if (!cnt_en_ni) cnt_q <= cnt_dec;
  end

  ddc_zero #(.W(W)) u_zero (
    .cur_i     (cnt_q),
    .cnt_en_ni (cnt_en_ni),
    .co_no     (co_no)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/ddc_chk.sv
module ddc_chk #(
  parameter int unsigned N_DIG    = 2,
  parameter bit          BCD_MODE = 1'b1,
  localparam int unsigned W       = N_DIG * 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         aload_ni,
  input logic         sload_ni,
  input logic         cnt_en_ni,
  input logic [W-1:0] jam_i,
  input logic [W-1:0] count_o,
  input logic         co_no
);
  localparam logic [63:0] MAX64 = ddc_pkg::max_count(BCD_MODE, N_DIG);
  localparam logic [W-1:0] MAX_V = MAX64[W-1:0];

  always @(negedge clk_i) begin
    if (!rst_ni) assert_clear_max_R1: assert (count_o == MAX_V);
  end

  assert_aload_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(!aload_ni) && !aload_ni) |-> (count_o == $past(jam_i)));

  assert_sload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !aload_ni)
    !sload_ni |=> (count_o == $past(jam_i)));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !aload_ni)
    (sload_ni && cnt_en_ni) |=> $stable(count_o));

  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !aload_ni)
    (sload_ni && !cnt_en_ni && count_o == '0) |=> (count_o == MAX_V));

  assert_co_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !co_no |-> (count_o == '0 && !cnt_en_ni));
endmodule

bind ddc_top ddc_chk #(.N_DIG(N_DIG), .BCD_MODE(BCD_MODE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .aload_ni(aload_ni), .sload_ni(sload_ni),
  .cnt_en_ni(cnt_en_ni), .jam_i(jam_i), .count_o(count_o), .co_no(co_no)
);

// File: tb/sim_ddc_top.sv
`timescale 1ns/1ps
module sim_ddc_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, aload_n, sload_n, en_n;
  logic [7:0] jam, cnt_d, cnt_b;
  logic       co_d, co_b;

  logic       c_sload_n, c_en_n;
  logic [7:0] c_jam_lo, c_jam_hi, c_lo, c_hi;
  logic       c_co_lo, c_co_hi;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  ddc_top #(.N_DIG(2), .BCD_MODE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .aload_ni(aload_n), .sload_ni(sload_n),
    .cnt_en_ni(en_n), .jam_i(jam), .count_o(cnt_d), .co_no(co_d));

  ddc_top #(.N_DIG(2), .BCD_MODE(1'b0)) u_bin (
    .clk_i(clk), .rst_ni(rst_n), .aload_ni(aload_n), .sload_ni(sload_n),
    .cnt_en_ni(en_n), .jam_i(jam), .count_o(cnt_b), .co_no(co_b));

  ddc_top #(.N_DIG(2), .BCD_MODE(1'b0)) u_lo (
    .clk_i(clk), .rst_ni(rst_n), .aload_ni(1'b1), .sload_ni(c_sload_n),
    .cnt_en_ni(c_en_n), .jam_i(c_jam_lo), .count_o(c_lo), .co_no(c_co_lo));

  ddc_top #(.N_DIG(2), .BCD_MODE(1'b0)) u_hi (
    .clk_i(clk), .rst_ni(rst_n), .aload_ni(1'b1), .sload_ni(c_sload_n),
    .cnt_en_ni(c_co_lo), .jam_i(c_jam_hi), .count_o(c_hi), .co_no(c_co_hi));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {sload_n, en_n, jam, exp count, exp co} for the decimal instance
  localparam int NV = 13;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h02, 8'h02, 1'b1},  // R4 load while disabled
    {1'b1, 1'b0, 8'h00, 8'h01, 1'b1},  // R6
    {1'b1, 1'b0, 8'h00, 8'h00, 1'b0},  // R8 zero and enabled
    {1'b1, 1'b0, 8'h00, 8'h99, 1'b1},  // R7 wrap
    {1'b1, 1'b1, 8'h00, 8'h99, 1'b1},  // R5 hold
    {1'b0, 1'b0, 8'h10, 8'h10, 1'b1},  // R4 load beats enable
    {1'b1, 1'b0, 8'h00, 8'h09, 1'b1},  // R6 decimal borrow
    {1'b1, 1'b1, 8'h00, 8'h09, 1'b1},  // R5
    {1'b0, 1'b1, 8'h00, 8'h00, 1'b1},  // R8 zero but disabled
    {1'b1, 1'b1, 8'h00, 8'h00, 1'b1},  // R5
    {1'b1, 1'b0, 8'h00, 8'h99, 1'b1},  // R7
    {1'b0, 1'b0, 8'h5F, 8'h5F, 1'b1},  // R9 invalid digit load
    {1'b1, 1'b0, 8'h00, 8'h5E, 1'b1}   // R9 invalid digit steps down
  };

  initial begin
    rst_n = 1'b0; aload_n = 1'b1; sload_n = 1'b1; en_n = 1'b1; jam = '0;
    c_sload_n = 1'b1; c_en_n = 1'b1; c_jam_lo = '0; c_jam_hi = '0;
    step(3);
    chk("R1 decimal clear", {8'h0, cnt_d}, 16'h0099);
    chk("R1 binary clear", {8'h0, cnt_b}, 16'h00FF);
    chk("R8 co idle", {15'h0, co_d}, 16'h1);
    rst_n = 1'b1;
    step(1);

    for (int i = 0; i < NV; i++) begin
      {sload_n, en_n, jam} = VEC[i][18:9];
      @(negedge clk);
      chk($sformatf("vec %0d count", i), {8'h0, cnt_d}, {8'h0, VEC[i][8:1]});
      chk($sformatf("vec %0d co R8", i), {15'h0, co_d}, {15'h0, VEC[i][0]});
    end

    // R9: 1F reaches 19 after six enabled edges
    sload_n = 1'b0; jam = 8'h1F; en_n = 1'b1;
    step(1);
    sload_n = 1'b1; en_n = 1'b0;
    step(6);
    chk("R9 1F to 19", {8'h0, cnt_d}, 16'h0019);

    // R10: A0 minus one differs by mode
    sload_n = 1'b0; jam = 8'hA0; en_n = 1'b1;
    step(1);
    sload_n = 1'b1; en_n = 1'b0;
    step(1);
    chk("R10 binary A0-1", {8'h0, cnt_b}, 16'h009F);
    chk("R6 decimal A0-1", {8'h0, cnt_d}, 16'h0099);
    en_n = 1'b1;
    step(1);

    // R2: async load without an edge, then held across an edge
    jam = 8'h47; sload_n = 1'b0; en_n = 1'b0;
    #1 aload_n = 1'b0;
    #0.5;
    chk("R2 async load now", {8'h0, cnt_d}, 16'h0047);
    step(1);
    chk("R2 held over edge", {8'h0, cnt_d}, 16'h0047);
    // R3: clear wins over async load
    #1 rst_n = 1'b0;
    #0.5;
    chk("R3 clear beats aload", {8'h0, cnt_d}, 16'h0099);
    chk("R3 clear beats aload bin", {8'h0, cnt_b}, 16'h00FF);
    aload_n = 1'b1; sload_n = 1'b1; en_n = 1'b1;
    step(1);
    rst_n = 1'b1;
    step(1);

    // R7/R8: 256 enabled edges; decimal wraps twice, binary once
    begin
      int lows_d = 0, lows_b = 0;
      en_n = 1'b0;
      for (int i = 0; i < 256; i++) begin
        #0.5;
        if (!co_d) lows_d++;
        if (!co_b) lows_b++;
        @(negedge clk);
      end
      en_n = 1'b1;
      chk("R7 decimal after 256", {8'h0, cnt_d}, 16'h0043);
      chk("R7 binary full cycle", {8'h0, cnt_b}, 16'h00FF);
      chk("R8 decimal co pulses", 16'(lows_d), 16'd2);
      chk("R8 binary co pulses", 16'(lows_b), 16'd1);
    end

    // R11: cascade 16'h0102 counts to zero after 258 edges, then wraps
    c_sload_n = 1'b0; c_jam_lo = 8'h02; c_jam_hi = 8'h01;
    step(1);
    chk("R11 cascade load", {c_hi, c_lo}, 16'h0102);
    c_sload_n = 1'b1; c_en_n = 1'b0;
    step(258);
    chk("R11 cascade zero", {c_hi, c_lo}, 16'h0000);
    step(1);
    chk("R11 cascade wrap", {c_hi, c_lo}, 16'hFFFF);
    c_en_n = 1'b1;
    step(1);
    chk("R5 cascade hold", {c_hi, c_lo}, 16'hFFFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule